// File: doc/BRIEF.md
# Four-Channel PWM Generator

This block produces four independent pulse-width modulated outputs from a single bus clock. Each channel is set by two 32-bit counts. The high-time count gives the number of clock ticks per cycle that the output is high. The cycle-length count gives the number of ticks in one full cycle. Software reaches both counts through a simple APB-style slave port and can read them back at any time.

Writes land in shadow registers. A channel that is running takes the shadow values only when its current cycle ends, so each cycle it produces uses one consistent pair of counts. A channel whose counts are both zero is stopped, and its output is held high. All outputs are high out of reset. A stopped channel takes a new setting on the clock after the write. Software should write the high-time count before the cycle length. Otherwise a stopped channel briefly runs with a zero high time.

Top module: `pwm_multi`

## Requirements
- R1: After reset, all eight count registers read 0 and every `pwm_out` bit is 1.
- R2: Channel c has its high-time count at byte offset 8*c and its cycle-length count at byte offset 8*c+4. Both are 32 bits wide, and a read returns the last value written.
- R3: A running channel with cycle length L > 0 and high time H counts ticks 0..L-1. Its output is 1 while the tick index is below H and 0 for the rest of the cycle, so the period is exactly L ticks.
- R4: If H >= L > 0, the output is 1 for the whole cycle. If H = 0 and L > 0, the output is 0 for the whole cycle.
- R5: A rewrite of either count while a channel is running does not affect the cycle in progress. The new value applies from the first tick of the next cycle.
- R6: When both counts of a channel are 0, that channel stops once its current cycle ends, and its output then stays 1.
- R7: A stopped channel that receives a nonzero setting loads it on the clock edge after the write and starts a new cycle at tick 0 in that same edge.
- R8: A read of an address outside the eight mapped word offsets (offset bits above bit 4 nonzero, or bits 1:0 nonzero) returns 0. A write to such an address changes no register and no output.
- R9: `pready` is always 1, so every transfer completes in its first access cycle.
- R10: Each channel's output depends only on that channel's own two counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for a write transfer, 0 for a read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer-complete flag, tied to 1 |
| pwm_out | output | 4 | One PWM output per channel, bit c for channel c |

## Verification
The bench writes high-time counts above the cycle length and a zero high time with a nonzero length. A design with an off-by-one comparator would show a one-tick glitch in those cycles. It rewrites a running channel in mid-cycle. An early reload would shorten or stretch that cycle against the reference model. It programs stopped channels and checks the exact edge of the first pulse. A design that waits for a boundary that never comes, or that leaves a zero-high-time stall, would miss that edge. It also writes to and reads from unmapped and misaligned offsets. A loose address decoder would alias those accesses onto a real channel register.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;
  localparam int unsigned PWM_NUM_CH = 4;
  localparam int unsigned PWM_DATA_W = 32;
  localparam int unsigned PWM_ADDR_W = 12;

  // byte stride between channel register pairs is 8: bits [1:0] select byte,
  // bit 2 picks high-time (0) or cycle length (1), bits above pick channel
  localparam int unsigned PWM_SEL_BIT = 2;
  localparam int unsigned PWM_CH_LSB  = 3;

  typedef enum logic {
    FLD_HIGH = 1'b0,
    FLD_LEN  = 1'b1
  } pwm_field_e;
endpackage

// File: rtl/pwm_multi_regs.sv
module pwm_multi_regs
  import pwm_multi_pkg::*;
#(
  parameter int unsigned NUM_CH = PWM_NUM_CH,
  parameter int unsigned DATA_W = PWM_DATA_W,
  parameter int unsigned ADDR_W = PWM_ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [DATA_W-1:0]             pwdata,
  output logic [DATA_W-1:0]             prdata,
  output logic [NUM_CH-1:0][DATA_W-1:0] hi_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] len_o
);
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned TOP_LSB = PWM_CH_LSB + CH_W;

  logic [CH_W-1:0] idx;
  pwm_field_e      fld;
  logic            hit;
  logic            wr_en;
  logic            rd_setup;

  always_comb begin
    idx      = paddr[PWM_CH_LSB +: CH_W];
    fld      = pwm_field_e'(paddr[PWM_SEL_BIT]);
    hit      = (paddr[1:0] == 2'b00)
            && (paddr[ADDR_W-1:TOP_LSB] == '0)
            && (32'(idx) < NUM_CH);
    wr_en    = psel && penable && pwrite && hit;
    rd_setup = psel && !penable && !pwrite;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_o[c]  <= '0;
        len_o[c] <= '0;
      end else if (wr_en && (32'(idx) == c)) begin
        if (fld == FLD_LEN) len_o[c] <= pwdata;
        else                hi_o[c]  <= pwdata;
      end
    end
  end

  // read data captured in the setup phase, presented in the access phase
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
    end else if (rd_setup) begin
      if (!hit)                 prdata <= '0;
      else if (fld == FLD_LEN)  prdata <= len_o[idx];
      else                      prdata <= hi_o[idx];
    end
  end
endmodule

// File: rtl/pwm_multi_chan.sv
module pwm_multi_chan #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sh_hi,
  input  logic [DATA_W-1:0] sh_len,
  output logic              pwm_o
);
  logic [DATA_W-1:0] act_hi;
  logic [DATA_W-1:0] act_len;
  logic [DATA_W-1:0] tick;
  logic [DATA_W-1:0] tick_nx;
  logic              wrap;

  // a zero length (stopped or degenerate) re-samples the shadow every clock,
  // which gives an idle channel its immediate start
  always_comb begin
    tick_nx = tick + 1'b1;
    wrap    = (act_len == '0) || (tick == act_len - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi  <= '0;
      act_len <= '0;
      tick    <= '0;
      pwm_o   <= 1'b1;
    end else if (wrap) begin
      act_hi  <= sh_hi;
      act_len <= sh_len;
      tick    <= '0;
      pwm_o   <= (sh_hi != '0) || (sh_len == '0);
    end else begin
      tick    <= tick_nx;
      pwm_o   <= (tick_nx < act_hi);
    end
  end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_multi_pkg::*;
#(
  parameter int unsigned NUM_CH = PWM_NUM_CH,
  parameter int unsigned DATA_W = PWM_DATA_W,
  parameter int unsigned ADDR_W = PWM_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0][DATA_W-1:0] shadow_hi;
  logic [NUM_CH-1:0][DATA_W-1:0] shadow_len;

  assign pready = 1'b1;

  pwm_multi_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .hi_o    (shadow_hi),
    .len_o   (shadow_len)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_multi_chan #(
      .DATA_W (DATA_W)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .sh_hi  (shadow_hi[c]),
      .sh_len (shadow_len[c]),
      .pwm_o  (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic [NUM_CH-1:0] pwm_out
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              mapped;
  logic              rst_q;
  logic              last_ok;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;

  always_comb begin
    mapped = (paddr[1:0] == 2'b00) && (paddr[ADDR_W-1:3+CH_W] == '0)
          && (32'(paddr[3 +: CH_W]) < NUM_CH);
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      last_ok   <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else if (psel && penable && pwrite && mapped) begin
      last_ok   <= 1'b1;
      last_addr <= paddr;
      last_data <= pwdata;
    end
  end

  // R1: the cycle after reset, all outputs are high
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      p_reset_high_r1: assert (pwm_out == {NUM_CH{1'b1}})
        else $error("R1: outputs not high after reset");
    end
  end

  // R9
  p_ready_r9: assert property (@(posedge clk) disable iff (rst) pready == 1'b1);

  // R8
  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable && !pwrite && !mapped) |=> (prdata == '0));

  // R2: reading the most recently written register returns its data
  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable && !pwrite && last_ok && (paddr == last_addr))
      |=> (prdata == $past(last_data)));
endmodule

bind pwm_multi pwm_multi_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .pready  (pready),
  .pwm_out (pwm_out)
);

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [3:0]  pwm_out;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R3";

  always #(CLK_P/2) clk = ~clk;

  pwm_multi u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pwm_out(pwm_out)
  );

  // reference model built from the requirements
  logic [31:0] m_sh_hi[NCH], m_sh_len[NCH];
  logic [31:0] m_hi[NCH], m_len[NCH], m_ph[NCH];
  logic        m_out[NCH];

  function automatic bit mapped(input logic [11:0] a);
    return (a[11:5] == 0) && (a[1:0] == 0);
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        m_sh_hi[c] <= 0; m_sh_len[c] <= 0;
        m_hi[c] <= 0; m_len[c] <= 0; m_ph[c] <= 0; m_out[c] <= 1'b1;
      end else begin
        if (psel && penable && pwrite && mapped(paddr) && paddr[4:3] == c) begin
          if (paddr[2]) m_sh_len[c] <= pwdata;
          else          m_sh_hi[c]  <= pwdata;
        end
        if (m_len[c] == 0 || m_ph[c] + 1 == m_len[c]) begin
          m_hi[c] <= m_sh_hi[c]; m_len[c] <= m_sh_len[c]; m_ph[c] <= 0;
          m_out[c] <= (m_sh_len[c] == 0) ? 1'b1 : (m_sh_hi[c] > 0);
        end else begin
          m_ph[c]  <= m_ph[c] + 1;
          m_out[c] <= (m_ph[c] + 1 < m_hi[c]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every channel against the model each cycle, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NCH; c++)
        check(pwm_out[c] === m_out[c], cur_req, 32'(pwm_out[c]), 32'(m_out[c]));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    check(pready === 1'b1, "R9", 32'(pready), 1);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rv;
  logic [31:0] exp_regs[8];
  bit          seq[6];

  initial begin
    void'($urandom(32'd20240911));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(pwm_out === 4'hF, "R1", 32'(pwm_out), 32'hF);
    for (int i = 0; i < 8; i++) begin
      rd(12'(i*4), rv);
      check(rv === 0, "R1", rv, 0);
    end

    // R7 + R3: stopped channel 0 gets H=3 then L=5
    cur_req = "R7";
    wr(12'h000, 3);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h004; pwdata = 5;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); seq[i] = pwm_out[0];
    end
    check(seq[0] && seq[1] && seq[2], "R7", {29'd0, seq[0], seq[1], seq[2]}, 7);
    check(!seq[3] && !seq[4] && seq[5], "R3", {29'd0, seq[3], seq[4], seq[5]}, 1);

    // R5: mid-cycle rewrite of running channel 0
    cur_req = "R5";
    idle(2); wr(12'h000, 1); idle(12);
    wr(12'h004, 7); idle(20);

    // R4: high time above length, and zero high time
    cur_req = "R4";
    wr(12'h008, 7); wr(12'h00C, 4);
    wr(12'h014, 4);
    idle(6);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(pwm_out[1] === 1'b1, "R4", 32'(pwm_out[1]), 1);
      check(pwm_out[2] === 1'b0, "R4", 32'(pwm_out[2]), 0);
    end

    // R6: stop channel 0
    cur_req = "R6";
    wr(12'h000, 0); wr(12'h004, 0);
    idle(10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(pwm_out[0] === 1'b1, "R6", 32'(pwm_out[0]), 1);
    end

    // R2: full map readback
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      exp_regs[i] = 32'h1000 + 32'(i) * 32'h11 + ((i % 2) ? 32'd8 : 32'd2);
      wr(12'(i*4), exp_regs[i]);
    end
    for (int i = 0; i < 8; i++) begin
      rd(12'(i*4), rv);
      check(rv === exp_regs[i], "R2", rv, exp_regs[i]);
    end

    // R8: unmapped and misaligned accesses
    cur_req = "R8";
    wr(12'h020, 32'hDEAD); wr(12'h102, 32'hBEEF); wr(12'h801, 32'h5);
    rd(12'h020, rv); check(rv === 0, "R8", rv, 0);
    rd(12'h006, rv); check(rv === 0, "R8", rv, 0);
    rd(12'hFFC, rv); check(rv === 0, "R8", rv, 0);
    for (int i = 0; i < 8; i++) begin
      rd(12'(i*4), rv);
      check(rv === exp_regs[i], "R8", rv, exp_regs[i]);
    end

    // R10 + R3: random programming across channels
    cur_req = "R10";
    for (int i = 0; i < 8; i++) wr(12'(i*4), 0);
    idle(40);
    for (int it = 0; it < 60; it++) begin
      int c;
      logic [31:0] h, l;
      c = $urandom % NCH;
      h = $urandom % 10;
      l = $urandom % 10;
      wr(12'(c*8), h);
      wr(12'(c*8 + 4), l);
      rd(12'(c*8 + 4), rv);
      check(rv === l, "R2", rv, l);
      idle($urandom % 25);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule